// File: doc/BRIEF.md
# S/PDIF Transmit Frame Encoder

This block turns PCM sample pairs into a biphase-mark serial line of the IEC 60958 kind. It runs on the audio master clock. A programmable divider cuts that clock down to one tick per half-cell, so each line cell is two ticks and each frame is 128 ticks. The divided rate must equal 128 times the sample rate. With a 22.5792 MHz master the 44.1 kHz family is reachable, and with a 24.576 MHz master the 48 kHz family. The divider is 1, 2, 4, 6 or 8, depending on the rate.

Each frame carries two 32-slot subframes:
- a preamble;
- a 24-bit audio word, sent LSB first, with shorter samples MSB-aligned;
- validity, user and channel-status bits;
- an even parity bit.

Channel status is stepped through a block of 192 frames, and the first frame of each block is marked by its own preamble.

A sample pair is taken with a valid/ready handshake once per frame. When no pair is offered, the frame carries silence marked invalid, and a sticky underrun flag is raised. Mono mode repeats one sample in both subframes. A non-audio flag marks the stream as data.

Top module: `spdif_tx_encoder`

## Requirements
- R1: Every half-cell of the line lasts exactly `cfg_ratio`+1 master-clock cycles (`cfg_ratio` holds the divider minus one).
- R2: `cfg_fmt` selects the sample width: 0 is 16-bit (port bits 15:0), 1 is 20-bit (bits 19:0), 2 and 3 are 24-bit. The sample is shifted up to the top of the 24-bit audio field in slots 4..27, sent LSB first, and the low bits are filled with zeros.
- R3: In each subframe the slots carry the following, and slots 4..31 hold an even number of ones:
  - slot 28: validity;
  - slot 29: user bit, always 0;
  - slot 30: channel-status bit;
  - slot 31: parity.
- R4: Slots 4..31 are biphase-mark coded. The level changes at every slot boundary, and it changes in mid-slot only for a 1.
- R5: Each subframe opens with an 8-half-cell preamble. Written for a preceding level of 0, the patterns are:
  - B: 11101000, which starts frame 0 of each 192-frame block;
  - M: 11100010, which starts the other left subframes;
  - W: 11100100, which starts right subframes.
  
  The pattern is inverted when the preceding level is 1. The line idles at 0.
- R6: With `cfg_mono` set, the left sample is sent in both subframes of the frame.
- R7: With `cfg_raw` set, channel-status bit 1 is 1 and the validity bit is 1 in every subframe.
- R8: Channel-status bit n is sent in slot 30 of both subframes of frame n of the block. Bits 24..27 carry `cfg_rate` (LSB at bit 24), bit 1 follows R7, and all other bits are 0.
- R9: `smp_ready` is high for one cycle at each frame start, including the cycle in which both enables are first seen. A pair is consumed only when `smp_valid` is high in that cycle.
- R10: A frame that starts with no valid pair sends zero audio with validity 1 in both subframes and sets `underrun`. `underrun` stays set until the next start from idle.
- R11: One clock after either enable clears, the line is 0 and no handshake occurs. A restart begins at frame 0 with preamble B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Audio master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| glb_en | input | 1 | Global enable |
| tx_en | input | 1 | Transmit enable |
| cfg_fmt | input | 2 | Sample width select |
| cfg_raw | input | 1 | Non-audio (data) stream flag |
| cfg_mono | input | 1 | Single-channel mode |
| cfg_ratio | input | 5 | Half-cell divider minus one |
| cfg_rate | input | 4 | Sample-rate code for channel status |
| smp_left | input | 24 | Left (or mono) sample, right-justified |
| smp_right | input | 24 | Right sample, right-justified |
| smp_valid | input | 1 | Sample pair offered |
| smp_ready | output | 1 | Pair taken this cycle when valid |
| line_out | output | 1 | Biphase-mark serial line |
| underrun | output | 1 | Sticky missed-sample flag |

## Verification
The bench decodes the line half-cell by half-cell and targets the following corner cases:
- Divider ratios from 0 to 7. A wrong divider shows up as a level that changes inside a half-cell.
- Wrap of the 192-frame block into a second B preamble. An off-by-one frame counter would put M there, or place the rate code in the wrong frames.
- Preamble polarity after both line levels. A design that ignores the preceding level emits inverted preambles.
- Frames with a missing sample, both from start and in mid-stream. A design that drops the validity bit or the sticky flag would then stream stale audio as valid.
- Stopping in mid-frame with the line high. A design that finishes the frame first leaves the line active.

// File: rtl/spdif_tx_pkg.sv
package spdif_tx_pkg;

    localparam int AUDIO_W    = 24;
    localparam int HALF_CELLS = 64;
    localparam int POS_W      = $clog2(HALF_CELLS);
    localparam int PRE_HALVES = 8;
    localparam int AUDIO_LO   = 4;
    localparam int SLOT_V     = 28;
    localparam int SLOT_U     = 29;
    localparam int SLOT_C     = 30;
    localparam int SLOT_P     = 31;

    typedef enum logic [1:0] {PRE_B, PRE_M, PRE_W} pre_kind_e;

    // Move a right-justified sample to the top of the 24-bit audio field.
    function automatic logic [AUDIO_W-1:0] align_sample(input logic [AUDIO_W-1:0] s,
                                                        input logic [1:0] fmt);
        case (fmt)
            2'd0:    return {s[15:0], 8'h00};
            2'd1:    return {s[19:0], 4'h0};
            default: return s;
        endcase
    endfunction

    // Toggle pattern of each preamble, first half-cell at bit 7.
    function automatic logic pre_toggle(input pre_kind_e k, input logic [2:0] idx);
        logic [7:0] p;
        case (k)
            PRE_B:   p = 8'b1001_1100;
            PRE_M:   p = 8'b1001_0011;
            default: p = 8'b1001_0110;
        endcase
        return p[3'd7 - idx];
    endfunction

    // Channel-status bit for a given frame of the block.
    function automatic logic cs_bit(input logic [7:0] idx, input logic raw,
                                    input logic [3:0] rate);
        if (idx == 8'd1) return raw;
        if (idx >= 8'd24 && idx <= 8'd27) return rate[idx[1:0]];
        return 1'b0;
    endfunction

endpackage

// File: rtl/spdif_tx_div.sv
module spdif_tx_div #(
    parameter int RATIO_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               active_i,
    input  logic [RATIO_W-1:0] ratio_i,
    output logic               tick_o
);
    typedef struct packed {
        logic [RATIO_W-1:0] cnt;
    } div_st_t;

    div_st_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        tick_o = active_i && (st_q.cnt == ratio_i);
        if (!active_i || tick_o) st_d.cnt = '0;
        else                     st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R1: with a divider above one, two ticks are never adjacent
    assert_tick_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && ratio_i != '0) |=> !tick_o);

endmodule

// File: rtl/spdif_tx_seq.sv
module spdif_tx_seq
    import spdif_tx_pkg::*;
#(
    parameter int FRAMES = 192
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_i,
    input  logic               tick_i,
    input  logic [1:0]         cfg_fmt_i,
    input  logic               cfg_raw_i,
    input  logic               cfg_mono_i,
    input  logic [3:0]         cfg_rate_i,
    input  logic [AUDIO_W-1:0] smp_left_i,
    input  logic [AUDIO_W-1:0] smp_right_i,
    input  logic               smp_valid_i,
    output logic               smp_ready_o,
    output logic               underrun_o,
    output logic               start_o,
    output logic               adv_o,
    output logic [POS_W-1:0]   pos_n_o,
    output pre_kind_e          kind_n_o,
    output logic [31:0]        word_o
);
    localparam int FW = $clog2(FRAMES);

    typedef struct packed {
        logic               active;
        logic [POS_W-1:0]   pos;
        logic               sf;
        logic [FW-1:0]      fr;
        logic [AUDIO_W-1:0] left;
        logic [AUDIO_W-1:0] right;
        logic               miss;
        logic               under;
        logic [31:0]        word;
    } seq_st_t;

    seq_st_t st_d, st_q;

    logic               start, adv, wrap, take;
    logic [AUDIO_W-1:0] chan;
    logic [31:0]        w;

    always_comb begin
        st_d  = st_q;
        start = run_i && !st_q.active;
        adv   = run_i && st_q.active && tick_i;
        wrap  = adv && (st_q.pos == POS_W'(HALF_CELLS - 1));
        take  = start || (wrap && st_q.sf);
        chan  = '0;
        w     = '0;

        if (!run_i) begin
            st_d.active = 1'b0;
            st_d.pos    = '0;
            st_d.sf     = 1'b0;
            st_d.fr     = '0;
        end else if (start) begin
            st_d.active = 1'b1;
            st_d.pos    = '0;
            st_d.sf     = 1'b0;
            st_d.fr     = '0;
            st_d.under  = 1'b0;
        end else if (adv) begin
            st_d.pos = st_q.pos + 1'b1;
            if (wrap) begin
                st_d.sf = !st_q.sf;
                if (st_q.sf)
                    st_d.fr = (st_q.fr == FW'(FRAMES - 1)) ? '0 : st_q.fr + 1'b1;
            end
        end

        if (take) begin
            if (smp_valid_i) begin
                st_d.left  = smp_left_i;
                st_d.right = cfg_mono_i ? smp_left_i : smp_right_i;
                st_d.miss  = 1'b0;
            end else begin
                st_d.left  = '0;
                st_d.right = '0;
                st_d.miss  = 1'b1;
                st_d.under = 1'b1;
            end
        end

        if (start || wrap) begin
            chan                              = st_d.sf ? st_d.right : st_d.left;
            w[AUDIO_LO +: AUDIO_W]            = align_sample(chan, cfg_fmt_i);
            w[SLOT_V]                         = cfg_raw_i || st_d.miss;
            w[SLOT_U]                         = 1'b0;
            w[SLOT_C]                         = cs_bit(8'(st_d.fr), cfg_raw_i, cfg_rate_i);
            w[SLOT_P]                         = ^w[SLOT_C:AUDIO_LO];
            st_d.word                         = w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign smp_ready_o = take;
    assign underrun_o  = st_q.under;
    assign start_o     = start;
    assign adv_o       = adv;
    assign pos_n_o     = st_d.pos;
    assign kind_n_o    = st_d.sf ? PRE_W : ((st_d.fr == '0) ? PRE_B : PRE_M);
    assign word_o      = st_q.word;

    // R9: a handshake always lands on the first half-cell of a left subframe
    assert_ready_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
        smp_ready_o |=> (st_q.active && st_q.pos == '0 && !st_q.sf));

    // R10: the underrun flag only falls on a fresh start
    assert_underrun_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.under && !start) |=> st_q.under);

    // R8: the frame counter never leaves the block
    assert_frame_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.active |-> (st_q.fr <= FW'(FRAMES - 1)));

endmodule

// File: rtl/spdif_tx_line.sv
module spdif_tx_line
    import spdif_tx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             step_i,
    input  logic [POS_W-1:0] pos_n_i,
    input  pre_kind_e        kind_n_i,
    input  logic [31:0]      word_i,
    output logic             line_o
);
    typedef struct packed {
        logic line;
    } line_st_t;

    line_st_t st_d, st_q;
    logic     tog;

    always_comb begin
        st_d = st_q;
        if (pos_n_i < POS_W'(PRE_HALVES))
            tog = pre_toggle(kind_n_i, pos_n_i[2:0]);
        else if (!pos_n_i[0])
            tog = 1'b1;
        else
            tog = word_i[pos_n_i[POS_W-1:1]];

        if (!run_i)      st_d.line = 1'b0;
        else if (step_i) st_d.line = st_q.line ^ tog;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign line_o = st_q.line;

    // R11: the line is idle one clock after the enables drop
    assert_idle_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> !line_o);

    // R4: a cell boundary outside the preamble body always flips the line
    assert_cell_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !pos_n_i[0] && (pos_n_i >= POS_W'(PRE_HALVES) || pos_n_i == '0))
        |=> (line_o != $past(line_o)));

endmodule

// File: rtl/spdif_tx_encoder.sv
module spdif_tx_encoder
    import spdif_tx_pkg::*;
#(
    parameter int RATIO_W = 5,
    parameter int FRAMES  = 192
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               glb_en,
    input  logic               tx_en,
    input  logic [1:0]         cfg_fmt,
    input  logic               cfg_raw,
    input  logic               cfg_mono,
    input  logic [RATIO_W-1:0] cfg_ratio,
    input  logic [3:0]         cfg_rate,
    input  logic [AUDIO_W-1:0] smp_left,
    input  logic [AUDIO_W-1:0] smp_right,
    input  logic               smp_valid,
    output logic               smp_ready,
    output logic               line_out,
    output logic               underrun
);
    logic             run, tick, start, adv, active;
    logic [POS_W-1:0] pos_n;
    pre_kind_e        kind_n;
    logic [31:0]      word;

    assign run    = glb_en && tx_en;
    assign active = run && !start;

    spdif_tx_div #(.RATIO_W(RATIO_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_i (active),
        .ratio_i  (cfg_ratio),
        .tick_o   (tick)
    );

    spdif_tx_seq #(.FRAMES(FRAMES)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_i       (run),
        .tick_i      (tick),
        .cfg_fmt_i   (cfg_fmt),
        .cfg_raw_i   (cfg_raw),
        .cfg_mono_i  (cfg_mono),
        .cfg_rate_i  (cfg_rate),
        .smp_left_i  (smp_left),
        .smp_right_i (smp_right),
        .smp_valid_i (smp_valid),
        .smp_ready_o (smp_ready),
        .underrun_o  (underrun),
        .start_o     (start),
        .adv_o       (adv),
        .pos_n_o     (pos_n),
        .kind_n_o    (kind_n),
        .word_o      (word)
    );

    spdif_tx_line u_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (run),
        .step_i   (start || adv),
        .pos_n_i  (pos_n),
        .kind_n_i (kind_n),
        .word_i   (word),
        .line_o   (line_out)
    );

endmodule

// File: tb/sim_spdif_tx_encoder.sv
module sim_spdif_tx_encoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        glb_en = 1'b0, tx_en = 1'b0;
    logic [1:0]  cfg_fmt = '0;
    logic        cfg_raw = 1'b0, cfg_mono = 1'b0;
    logic [4:0]  cfg_ratio = '0;
    logic [3:0]  cfg_rate = '0;
    logic [23:0] smp_left = '0, smp_right = '0;
    logic        smp_valid = 1'b0;
    logic        smp_ready, line_out, underrun;

    int nchk = 0, nfail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    spdif_tx_encoder u0 (
        .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .tx_en(tx_en),
        .cfg_fmt(cfg_fmt), .cfg_raw(cfg_raw), .cfg_mono(cfg_mono),
        .cfg_ratio(cfg_ratio), .cfg_rate(cfg_rate),
        .smp_left(smp_left), .smp_right(smp_right), .smp_valid(smp_valid),
        .smp_ready(smp_ready), .line_out(line_out), .underrun(underrun)
    );

    typedef struct packed {
        logic [1:0]  fmt;
        logic        raw;
        logic        mono;
        logic [4:0]  ratio;
        logic [3:0]  rate;
        logic        valid;
        logic [23:0] l;
        logic [23:0] r;
        logic [23:0] el;
        logic [23:0] er;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{2'd0, 1'b0, 1'b0, 5'd0, 4'h2, 1'b1, 24'h001234, 24'hFF8001, 24'h123400, 24'h800100},
        '{2'd1, 1'b0, 1'b0, 5'd3, 4'h0, 1'b1, 24'h0ABCDE, 24'h050001, 24'hABCDE0, 24'h500010},
        '{2'd2, 1'b1, 1'b0, 5'd1, 4'h3, 1'b1, 24'hC3A5F0, 24'h00000F, 24'hC3A5F0, 24'h00000F},
        '{2'd2, 1'b0, 1'b1, 5'd5, 4'hE, 1'b1, 24'h7FFFFF, 24'h123456, 24'h7FFFFF, 24'h7FFFFF},
        '{2'd3, 1'b0, 1'b0, 5'd7, 4'h8, 1'b1, 24'h800000, 24'h000001, 24'h800000, 24'h000001},
        '{2'd0, 1'b0, 1'b0, 5'd0, 4'h1, 1'b0, 24'h00FFFF, 24'h00FFFF, 24'h000000, 24'h000000}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic exp_cs(input int f, input logic raw, input logic [3:0] rate);
        int m = f % 192;
        if (m == 1) return raw;
        if (m >= 24 && m <= 27) return rate[m-24];
        return 1'b0;
    endfunction

    task automatic run_case(input logic [1:0] fmt, input logic raw, input logic mono,
                            input logic [4:0] ratio, input logic [3:0] rate,
                            input logic [23:0] l, input logic [23:0] r,
                            input logic [23:0] el, input logic [23:0] er,
                            input int nvalid, input int nframes, input bit by_glb);
        logic [63:0] hv;
        logic [31:0] dw, ew;
        logic [7:0]  pgot, pexp;
        logic        prev, pending, unstable, edges_ok, miss;
        int          rdy, taken;
        string       atag, vtag;
        cfg_fmt = fmt; cfg_raw = raw; cfg_mono = mono; cfg_ratio = ratio; cfg_rate = rate;
        smp_left = l; smp_right = r; smp_valid = (nvalid > 0);
        glb_en = 1'b1; tx_en = 1'b1;
        #1;
        chk(smp_ready === 1'b1, "R9", "ready at start", {31'd0, smp_ready}, 32'd1);
        taken = 1; pending = 1'b1; rdy = 0; prev = 1'b0;
        @(posedge clk);
        for (int f = 0; f < nframes; f++) begin
            for (int sf = 0; sf < 2; sf++) begin
                unstable = 1'b0;
                hv = '0;
                for (int k = 0; k < 64; k++) begin
                    for (int c = 0; c <= int'(ratio); c++) begin
                        @(negedge clk);
                        if (pending) begin
                            smp_valid = (taken < nvalid);
                            pending = 1'b0;
                        end
                        if (smp_ready) begin
                            rdy++; taken++; pending = 1'b1;
                        end
                        if (c == 0) hv[k] = line_out;
                        else if (line_out !== hv[k]) unstable = 1'b1;
                    end
                end
                for (int k = 0; k < 8; k++) pgot[7-k] = hv[k];
                pexp = ((f % 192 == 0) && sf == 0) ? 8'hE8 : (sf == 0 ? 8'hE2 : 8'hE4);
                pexp = pexp ^ {8{prev}};
                dw = '0; edges_ok = 1'b1;
                for (int s = 4; s < 32; s++) begin
                    if (hv[2*s] == hv[2*s-1]) edges_ok = 1'b0;
                    dw[s] = hv[2*s] ^ hv[2*s+1];
                end
                miss = (f >= nvalid);
                ew = '0;
                ew[27:4] = miss ? 24'h0 : (sf == 1 ? er : el);
                ew[28] = raw | miss;
                ew[30] = exp_cs(f, raw, rate);
                ew[31] = ^ew[30:4];
                atag = mono ? "R6" : (miss ? "R10" : "R2");
                vtag = raw ? "R7" : (miss ? "R10" : "R3");
                chk(!unstable, "R1", "half-cell held ratio+1 clocks", {31'd0, unstable}, 32'd0);
                chk(pgot == pexp, "R5", "preamble", {24'd0, pgot}, {24'd0, pexp});
                chk(edges_ok, "R4", "slot boundary transitions", {31'd0, edges_ok}, 32'd1);
                chk(dw[27:4] == ew[27:4], atag, "audio field", {8'd0, dw[27:4]}, {8'd0, ew[27:4]});
                chk(dw[28] == ew[28], vtag, "validity bit", {31'd0, dw[28]}, {31'd0, ew[28]});
                chk(dw[30] == ew[30], "R8", "channel-status bit", {31'd0, dw[30]}, {31'd0, ew[30]});
                chk({dw[31], dw[29]} == {ew[31], ew[29]}, "R3", "parity and user bit",
                    {30'd0, dw[31], dw[29]}, {30'd0, ew[31], ew[29]});
                prev = hv[63];
            end
        end
        chk(rdy == nframes, "R9", "handshakes per run", rdy, nframes);
        chk(underrun === (nvalid < nframes), "R10", "underrun flag",
            {31'd0, underrun}, {31'd0, (nvalid < nframes)});
        if (by_glb) glb_en = 1'b0; else tx_en = 1'b0;
        @(negedge clk);
        chk(line_out === 1'b0 && smp_ready === 1'b0, "R11", "idle after enable drop",
            {30'd0, line_out, smp_ready}, 32'd0);
        repeat (5) @(negedge clk);
        chk(line_out === 1'b0, "R11", "line stays idle", {31'd0, line_out}, 32'd0);
        glb_en = 1'b0; tx_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(line_out === 1'b0 && smp_ready === 1'b0, "R11", "reset idle line",
            {30'd0, line_out, smp_ready}, 32'd0);
        chk(underrun === 1'b0, "R10", "reset underrun clear", {31'd0, underrun}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < 6; i++)
            run_case(VECS[i].fmt, VECS[i].raw, VECS[i].mono, VECS[i].ratio, VECS[i].rate,
                     VECS[i].l, VECS[i].r, VECS[i].el, VECS[i].er,
                     VECS[i].valid ? 1000 : 0, 3, (i % 2) == 1);

        // sample drops out after the first frame; flag set while running
        run_case(2'd0, 1'b0, 1'b0, 5'd0, 4'h2, 24'h00ABCD, 24'h001111,
                 24'hABCD00, 24'h111100, 1, 3, 1'b0);

        // full block wrap with rate code in frames 24..27; also clears underrun
        run_case(2'd2, 1'b0, 1'b0, 5'd0, 4'hA, 24'h135790, 24'h2468AC,
                 24'h135790, 24'h2468AC, 1000, 194, 1'b0);

        // stop in mid-frame with the line high, then restart from idle
        cfg_ratio = 5'd1; smp_valid = 1'b1;
        glb_en = 1'b1; tx_en = 1'b1;
        repeat (300) @(negedge clk);
        while (line_out !== 1'b1) @(negedge clk);
        tx_en = 1'b0;
        @(negedge clk);
        chk(line_out === 1'b0, "R11", "mid-frame stop", {31'd0, line_out}, 32'd0);
        repeat (200) begin
            @(negedge clk);
            if (smp_ready !== 1'b0)
                chk(1'b0, "R11", "handshake while stopped", {31'd0, smp_ready}, 32'd0);
        end
        glb_en = 1'b0;
        run_case(2'd1, 1'b1, 1'b1, 5'd2, 4'h6, 24'h0FEDCB, 24'h000000,
                 24'hFEDCB0, 24'hFEDCB0, 1000, 2, 1'b1);

        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        done = 1'b1;
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog run did not finish actual=0 expected=1");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

endmodule